// File: doc/BRIEF.md
# Serial Flash IO3 Reset and Hold Detector

This block sits on the device side of a serial flash, next to the pad of the fourth data line (IO3). Depending on two configuration bits, quad enable and a hold-or-reset choice, that pin is plain data, a hold input or a reset input. The block works out the role of the pin from those bits and chip select. It measures how long the pin stays low while a reset is allowed. When a reset qualifies, it issues a one-cycle reset request and opens a recovery window.

The block does not decode commands or touch the memory array. It gives those parts a reset request pulse, which clears the volatile status and configuration state and stops the operation in progress. It also gives them a recovery-busy level, which puts the output drivers in high impedance and makes them refuse commands. The bank address register lives here and is cleared by every reset.

In quad mode the pin carries traffic while chip select is low. For a blanking time after chip select rises, a low level on the pin does not count toward a reset. A separate dedicated reset pin overrides everything else. All times are counted in clock cycles and set by parameters.

Top module: `io3_rst_detect`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `reset_req`, `recov_busy`, `hold_active`, `iface_reset` and `io3_data_mode` are 0 and `bank_addr` is 0.
- R2: With `cfg_pin_is_rst`=0 the pin is a hold input. If quad mode is off and chip select is low, `hold_active` is 1 in the cycle after a sample with `io3_in`=0. In this setting a low level on `io3_in` never causes a reset.
- R3: If `hold_active` is 1 and chip select is then sampled high, `iface_reset` is 1 for exactly one cycle.
- R4: With `cfg_quad`=1 and `cs_n`=0, `io3_data_mode` is 1 in the next cycle. In that state `io3_in` causes neither hold nor reset.
- R5: With `cfg_pin_is_rst`=1 and `cs_n`=1, a reset needs MIN_LOW_CYC consecutive samples with `io3_in`=0. A run one sample shorter has no effect.
- R6: In quad mode, the first BLANK_CYC samples with chip select high after it rises do not count toward R5. With quad mode off there is no blanking.
- R7: `reset_req` is a one-cycle pulse in the cycle after the qualifying sample. If the pin stays low, no further pulse follows until the pin is released.
- R8: `recov_busy` rises together with `reset_req` and stays high for RECOV_CYC cycles. While it is high, no new shared-pin reset is counted and hold is not entered.
- R9: A reset sets `bank_addr` to 0. With `bank_we`=1, `bank_addr` takes `bank_wdata` in the next cycle, except while `recov_busy` is high or the dedicated reset is low, when the write is ignored.
- R10: The first sample with `dedi_rst_n`=0 raises `reset_req`, whatever the state of chip select, IO3 or the configuration bits. `recov_busy` stays high while the pin is low and for RECOV_CYC cycles after its release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Power-on reset, active low |
| cs_n | input | 1 | Chip select, active low |
| io3_in | input | 1 | Sampled level of the shared IO3 pin |
| dedi_rst_n | input | 1 | Dedicated reset pin, active low |
| cfg_quad | input | 1 | Quad enable configuration bit |
| cfg_pin_is_rst | input | 1 | 1: shared pin acts as reset, 0: hold (default) |
| bank_we | input | 1 | Bank address write strobe from the command logic |
| bank_wdata | input | BANK_W | Bank address write value |
| io3_data_mode | output | 1 | IO3 currently carries data only |
| hold_active | output | 1 | Hold condition in force |
| iface_reset | output | 1 | Pulse: interface logic reset after hold and deselect |
| reset_req | output | 1 | Pulse: terminate operation, clear volatile state |
| recov_busy | output | 1 | Recovery window; outputs high impedance, commands refused |
| bank_addr | output | BANK_W | Bank address register |

## Verification
The hardest case to reach is a reset in quad mode. It needs chip select to rise while IO3 is already low, and the pin must then stay low across the whole blanking time and the minimum low time. The stimulus covers the two edges of that window. It holds IO3 low through the rise for one sample less than blanking plus the minimum, then for exactly that many samples. It also holds IO3 low during data traffic with chip select low, and asserts the dedicated reset in the middle of that traffic. A behavioural model built on run lengths predicts every output in every cycle.

// File: rtl/io3_rst_pkg.sv
package io3_rst_pkg;

    typedef enum logic [1:0] {
        ROLE_NONE  = 2'd0,
        ROLE_DATA  = 2'd1,
        ROLE_HOLD  = 2'd2,
        ROLE_RESET = 2'd3
    } pin_role_e;

    // Decide what the shared pin means in the current cycle.
    function automatic pin_role_e pin_role(input logic quad_en,
                                           input logic rst_sel,
                                           input logic cs_n);
        pin_role_e r;
        if (quad_en && !cs_n)
            r = ROLE_DATA;
        else if (rst_sel && cs_n)
            r = ROLE_RESET;
        else if (!rst_sel && !quad_en)
            r = ROLE_HOLD;
        else
            r = ROLE_NONE;
        return r;
    endfunction

endpackage

// File: rtl/io3_blank_timer.sv
module io3_blank_timer #(
    parameter int BLANK_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic quad_en,
    output logic blanked
);
    localparam int CW = $clog2(BLANK_CYC + 1);

    typedef struct packed {
        logic          cs_prev;
        logic [CW-1:0] left;
    } blank_st_t;

    blank_st_t st_d, st_q;
    logic      rise;

    always_comb begin
        st_d         = st_q;
        rise         = cs_n && !st_q.cs_prev;
        st_d.cs_prev = cs_n;
        if (!cs_n)
            st_d.left = '0;
        else if (rise)
            st_d.left = CW'(BLANK_CYC - 1);
        else if (st_q.left != '0)
            st_d.left = st_q.left - 1'b1;
        blanked = quad_en && cs_n && (rise || (st_q.left != '0));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cs_prev <= 1'b1;
            st_q.left    <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/io3_low_filter.sv
module io3_low_filter #(
    parameter int MIN_LOW_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic qualify,
    input  logic freeze,
    output logic fire
);
    localparam int CW = $clog2(MIN_LOW_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] run;
    } low_st_t;

    low_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        fire = 1'b0;
        if (!qualify) begin
            st_d.run = '0;
        end else if (!freeze) begin
            if (st_q.run == CW'(MIN_LOW_CYC - 1))
                fire = 1'b1;
            if (st_q.run != CW'(MIN_LOW_CYC))
                st_d.run = st_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/io3_recov_timer.sv
module io3_recov_timer #(
    parameter int RECOV_CYC = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hold_on,
    output logic busy
);
    localparam int CW = $clog2(RECOV_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] left;
    } recov_st_t;

    recov_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start || hold_on)
            st_d.left = CW'(RECOV_CYC);
        else if (st_q.left != '0)
            st_d.left = st_q.left - 1'b1;
        busy = (st_q.left != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/io3_rst_detect.sv
module io3_rst_detect
    import io3_rst_pkg::*;
#(
    parameter int BLANK_CYC   = 4,
    parameter int MIN_LOW_CYC = 6,
    parameter int RECOV_CYC   = 10,
    parameter int BANK_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              io3_in,
    input  logic              dedi_rst_n,
    input  logic              cfg_quad,
    input  logic              cfg_pin_is_rst,
    input  logic              bank_we,
    input  logic [BANK_W-1:0] bank_wdata,
    output logic              io3_data_mode,
    output logic              hold_active,
    output logic              iface_reset,
    output logic              reset_req,
    output logic              recov_busy,
    output logic [BANK_W-1:0] bank_addr
);
    typedef struct packed {
        logic              ded_prev;
        logic              hold;
        logic              iface;
        logic              req;
        logic              data_mode;
        logic [BANK_W-1:0] bank;
    } top_st_t;

    top_st_t   st_d, st_q;
    pin_role_e role;
    logic      blanked;
    logic      qual_low;
    logic      busy;
    logic      shared_fire;
    logic      trig;

    io3_blank_timer #(.BLANK_CYC(BLANK_CYC)) i_blank (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .quad_en (cfg_quad),
        .blanked (blanked)
    );

    io3_low_filter #(.MIN_LOW_CYC(MIN_LOW_CYC)) i_low (
        .clk     (clk),
        .rst_n   (rst_n),
        .qualify (qual_low),
        .freeze  (busy),
        .fire    (shared_fire)
    );

    io3_recov_timer #(.RECOV_CYC(RECOV_CYC)) i_recov (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (trig),
        .hold_on (!dedi_rst_n),
        .busy    (busy)
    );

    always_comb begin
        st_d     = st_q;
        role     = pin_role(cfg_quad, cfg_pin_is_rst, cs_n);
        qual_low = (role == ROLE_RESET) && !blanked && dedi_rst_n && !io3_in;
        trig     = shared_fire || (!dedi_rst_n && st_q.ded_prev);

        st_d.ded_prev  = dedi_rst_n;
        st_d.req       = trig;
        st_d.data_mode = (role == ROLE_DATA);
        st_d.hold      = (role == ROLE_HOLD) && !cs_n && !io3_in
                         && dedi_rst_n && !busy;
        st_d.iface     = st_q.hold && cs_n;

        if (trig)
            st_d.bank = '0;
        else if (bank_we && !busy && dedi_rst_n)
            st_d.bank = bank_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q          <= '0;
            st_q.ded_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign io3_data_mode = st_q.data_mode;
    assign hold_active   = st_q.hold;
    assign iface_reset   = st_q.iface;
    assign reset_req     = st_q.req;
    assign recov_busy    = busy;
    assign bank_addr     = st_q.bank;
endmodule

// File: rtl/io3_rst_detect_chk.sv
module io3_rst_detect_chk #(
    parameter int BANK_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              dedi_rst_n,
    input logic              cfg_quad,
    input logic              cfg_pin_is_rst,
    input logic              hold_active,
    input logic              iface_reset,
    input logic              reset_req,
    input logic              recov_busy,
    input logic [BANK_W-1:0] bank_addr
);
    // R7: request lasts a single cycle
    a_r7_req_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);

    // R8: recovery window is open whenever a request is shown
    a_r8_busy_with_req: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> recov_busy);

    // R9: bank address is zero alongside the request
    a_r9_bank_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |-> (bank_addr == '0));

    // R10: dedicated pin low means busy next cycle
    a_r10_dedicated_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !dedi_rst_n |=> recov_busy);

    // R3: interface reset only follows an active hold
    a_r3_iface_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        iface_reset |-> $past(hold_active));

    // R4: quad traffic with select low never produces hold
    a_r4_quad_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_quad && !cs_n) |=> !hold_active);

    // R2: reset selected disables hold
    a_r2_rst_sel_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_pin_is_rst |=> !hold_active);
endmodule

bind io3_rst_detect io3_rst_detect_chk #(.BANK_W(BANK_W)) i_io3_rst_detect_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cs_n           (cs_n),
    .dedi_rst_n     (dedi_rst_n),
    .cfg_quad       (cfg_quad),
    .cfg_pin_is_rst (cfg_pin_is_rst),
    .hold_active    (hold_active),
    .iface_reset    (iface_reset),
    .reset_req      (reset_req),
    .recov_busy     (recov_busy),
    .bank_addr      (bank_addr)
);

// File: tb/test_io3_rst_detect.sv
`timescale 1ns/1ps
module test_io3_rst_detect;
    localparam int BLANK  = 4;
    localparam int MINLOW = 6;
    localparam int RECOV  = 10;
    localparam int BW     = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, io3_in = 1'b1, dedi_rst_n = 1'b1;
    logic cfg_quad = 1'b0, cfg_pin_is_rst = 1'b0, bank_we = 1'b0;
    logic [BW-1:0] bank_wdata = '0;
    logic io3_data_mode, hold_active, iface_reset, reset_req, recov_busy;
    logic [BW-1:0] bank_addr;

    int errors = 0;
    int checks = 0;
    int pulses = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    io3_rst_detect #(.BLANK_CYC(BLANK), .MIN_LOW_CYC(MINLOW),
                     .RECOV_CYC(RECOV), .BANK_W(BW)) i_io3_rst_detect (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .io3_in(io3_in),
        .dedi_rst_n(dedi_rst_n), .cfg_quad(cfg_quad),
        .cfg_pin_is_rst(cfg_pin_is_rst), .bank_we(bank_we),
        .bank_wdata(bank_wdata), .io3_data_mode(io3_data_mode),
        .hold_active(hold_active), .iface_reset(iface_reset),
        .reset_req(reset_req), .recov_busy(recov_busy), .bank_addr(bank_addr));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model, run lengths and countdowns
    int  m_cs_run, m_low_run, m_recov;
    bit  m_ded_prev, m_hold, m_iface, m_req, m_data;
    int  m_bank;
    bit  m_valid = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cs_run = 1000000; m_low_run = 0; m_recov = 0;
            m_ded_prev = 1; m_hold = 0; m_iface = 0; m_req = 0; m_data = 0;
            m_bank = 0; m_valid = 1;
        end else begin
            bit busy, blanked, qual, fire, trig;
            busy = (m_recov > 0);
            if (cs_n) m_cs_run = (m_cs_run < 1000000) ? m_cs_run + 1 : m_cs_run;
            else      m_cs_run = 0;
            blanked = cfg_quad && cs_n && (m_cs_run <= BLANK);
            qual = cfg_pin_is_rst && cs_n && !blanked && dedi_rst_n && !io3_in;
            fire = 0;
            if (!qual) m_low_run = 0;
            else if (!busy) begin
                m_low_run++;
                fire = (m_low_run == MINLOW);
            end
            trig = fire || (!dedi_rst_n && m_ded_prev);
            m_iface = m_hold && cs_n;
            m_hold = !cfg_pin_is_rst && !cfg_quad && !cs_n && !io3_in && dedi_rst_n && !busy;
            m_data = cfg_quad && !cs_n;
            if (trig) m_bank = 0;
            else if (bank_we && !busy && dedi_rst_n) m_bank = int'(bank_wdata);
            if (trig || !dedi_rst_n) m_recov = RECOV;
            else if (m_recov > 0)    m_recov--;
            m_req = trig;
            m_ded_prev = dedi_rst_n;
        end
    end

    always @(negedge clk) begin
        if (rst_n && m_valid) begin
            check(reset_req == m_req, "R7 reset_req", reset_req, m_req);
            check(recov_busy == (m_recov > 0), "R8 recov_busy", recov_busy, m_recov > 0);
            check(hold_active == m_hold, "R2 hold_active", hold_active, m_hold);
            check(iface_reset == m_iface, "R3 iface_reset", iface_reset, m_iface);
            check(io3_data_mode == m_data, "R4 io3_data_mode", io3_data_mode, m_data);
            check(int'(bank_addr) == m_bank, "R9 bank_addr", bank_addr, m_bank);
            if (reset_req) pulses++;
        end
    end

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        int p0;
        tick(3);
        check(!reset_req && !recov_busy && !hold_active && !iface_reset
              && !io3_data_mode && bank_addr == 0, "R1 state in reset", 1, 0);
        rst_n = 1'b1;
        tick(1);
        check(!reset_req && !recov_busy && bank_addr == 0, "R1 state after reset", recov_busy, 0);

        // bank write
        bank_we = 1; bank_wdata = 8'h5A; tick(1); bank_we = 0; tick(1);
        check(bank_addr == 8'h5A, "R9 bank write", bank_addr, 8'h5A);

        // shared reset, quad off
        cfg_pin_is_rst = 1;
        p0 = pulses; io3_in = 0; tick(MINLOW - 1); io3_in = 1; tick(3);
        check(pulses == p0, "R5 short low run", pulses - p0, 0);
        p0 = pulses; io3_in = 0; tick(MINLOW);
        check(reset_req && recov_busy, "R5 exact low run", reset_req, 1);
        check(bank_addr == 0, "R9 bank cleared", bank_addr, 0);
        bank_we = 1; bank_wdata = 8'h33; tick(1); bank_we = 0;
        tick(3 * MINLOW + RECOV);
        check(pulses == p0 + 1, "R7 single pulse while held", pulses - p0, 1);
        check(bank_addr == 0, "R9 write ignored in recovery", bank_addr, 0);
        io3_in = 1; tick(2);

        // quad mode
        cfg_quad = 1; cs_n = 0; p0 = pulses;
        for (int i = 0; i < 3 * MINLOW; i++) begin io3_in = i[0]; tick(1); end
        io3_in = 0; tick(2 * MINLOW);
        check(io3_data_mode == 1, "R4 data mode", io3_data_mode, 1);
        check(pulses == p0, "R4 no reset on data", pulses - p0, 0);
        cs_n = 1; tick(BLANK + MINLOW - 1); io3_in = 1; tick(2);
        check(pulses == p0, "R6 blanked run too short", pulses - p0, 0);
        cs_n = 0; tick(1); cs_n = 1; io3_in = 0; tick(BLANK + MINLOW);
        check(reset_req == 1, "R6 reset after blanking", reset_req, 1);
        io3_in = 1; tick(RECOV + 2);

        // hold mode
        cfg_quad = 0; cfg_pin_is_rst = 0; cs_n = 0; io3_in = 0; tick(2);
        check(hold_active == 1, "R2 hold", hold_active, 1);
        cs_n = 1; tick(1);
        check(iface_reset == 1, "R3 interface reset", iface_reset, 1);
        tick(1);
        check(iface_reset == 0, "R3 pulse ends", iface_reset, 0);
        p0 = pulses; tick(3 * MINLOW);
        check(pulses == p0, "R2 no reset in hold mode", pulses - p0, 0);
        io3_in = 1; tick(1);

        // dedicated reset amid quad traffic
        cfg_quad = 1; cfg_pin_is_rst = 1; cs_n = 0; p0 = pulses;
        io3_in = 0; dedi_rst_n = 0; tick(1);
        check(reset_req == 1, "R10 dedicated request", reset_req, 1);
        bank_we = 1; bank_wdata = 8'h77; tick(19); bank_we = 0;
        check(recov_busy == 1, "R10 busy while held", recov_busy, 1);
        dedi_rst_n = 1; tick(RECOV - 1);
        check(recov_busy == 1, "R10 busy tail", recov_busy, 1);
        tick(1);
        check(recov_busy == 0, "R10 busy released", recov_busy, 0);
        check(pulses == p0 + 1 && bank_addr == 0, "R10 one request, bank clear", pulses - p0, 1);
        io3_in = 1; cs_n = 1; tick(5);

        done = 1'b1;
        summary();
    end
endmodule